// File: doc/BRIEF.md
# Framed SPI Word Engine

This block moves 8-bit or 16-bit words over a serial link whose words are marked by a frame sync. The sync is a one-SCK-period, active-high pulse on a dedicated pin. It is not a select level held for the whole word. Four pairings are supported, chosen by two mode inputs:

- The block either drives the serial clock from a fixed divider of its system clock, or takes the serial clock from outside.
- The block either drives the frame sync, or waits for a sync pulse from outside.

When the block drives the clock, the clock runs continuously, whether or not a word is in flight.

Software-side logic places a word in a one-entry transmit buffer. It takes finished words from a one-entry receive buffer, which carries a full flag and a sticky overflow flag. A one-cycle completion pulse marks every finished word.

The polarity input chooses which serial clock edge is the leading (transmit) edge:

- Polarity 0: the rising edge leads.
- Polarity 1: the falling edge leads.

Outgoing data and the driven sync change only on leading edges. Incoming data and an external sync are sampled on trailing edges.

An external serial clock passes through a synchronizer chain before edge detection. The external sync and serial data input are expected to be timed to that serial clock.

Top module: `fspi_frame_engine`

## Requirements
- R1: After reset, tx_full, rx_full, rx_ovf, fs_out and done are all 0.
- R2: With cfg_clk_master=1, sck_oe is 1 and sck_out toggles once every HALF_DIV system clock cycles, with or without traffic. With cfg_clk_master=0, sck_oe is 0 and the edges of sck_in time the link.
- R3: With cfg_frame_master=1, fs_oe is 1. A buffered word raises fs_out on the next leading edge, and fs_out stays high for exactly one serial clock period (2*HALF_DIV system cycles when the clock is internal). With cfg_frame_master=0, fs_oe is 0 and fs_out stays 0.
- R4: A word is sent on sdo most significant bit first. Its first bit appears on the leading edge that ends the driven sync pulse (frame master), or on the first leading edge after fs_in is sampled high (frame slave). cfg_wide=0 sends tx_data[7:0] as 8 bits; cfg_wide=1 sends all 16 bits.
- R5: sdi is sampled on trailing edges, most significant bit first. The finished word appears on rx_data, with bits 15:8 zero in 8-bit mode.
- R6: In frame slave mode, a sampled sync pulse starts a word even when nothing new was written. The transmit buffer contents are sent again.
- R7: When cfg_cpol=0 the leading edge is the rising edge of the serial clock; when cfg_cpol=1 it is the falling edge. sdo and fs_out change only right after a leading edge.
- R8: A sync pulse that arrives while a word is shifting is ignored. A word written meanwhile stays buffered (tx_full=1) and does not start until a later sync.
- R9: A finished word is stored and rx_full is set only when rx_full and rx_ovf are both 0. Otherwise the word is dropped and rx_ovf is set. rx_full holds until rx_rd; rx_ovf holds until ovf_clr.
- R10: done pulses for exactly one system cycle per finished word, in the same cycle that rx_full or rx_ovf updates.
- R11: tx_wr sets tx_full on the next cycle. The block clears tx_full when it moves the buffer into the shift register, unless a write arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_master | input | 1 | 1: drive serial clock from the divider |
| cfg_frame_master | input | 1 | 1: drive the frame sync |
| cfg_cpol | input | 1 | Serial clock polarity; chooses the leading edge |
| cfg_wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Drive enable for the sync pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit buffer holds a word not yet loaded |
| rx_rd | input | 1 | Consume the received word |
| rx_data | output | 16 | Last stored received word |
| rx_full | output | 1 | Received word waiting |
| rx_ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears rx_ovf |
| done | output | 1 | One-cycle pulse per finished word |

## Verification
The hardest state to reach from the ports is a second sync pulse landing in the middle of a word while another word already waits in the transmit buffer. Reaching it needs the pulse placed several leading edges into the shift, with an external clock whose edges reach the block only through the synchronizer. The stimulus counts the leading edges it observes on the serial clock pin. It raises fs_in a fixed number of edges after the first sync and then watches for a single completion and a still-full buffer. Random words across all four mode pairings, both polarities and both widths run against a bench-side serial peer, which compares what it captured with what was written.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LEAD,
    ST_SHIFT
  } fspi_state_e;
endpackage

// File: rtl/fspi_clkgen.sv
// Serial clock source: free-running divider or synchronized external clock.
// Emits leading/trailing edge strobes in the system clock domain.
module fspi_clkgen #(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clk_master,
  input  logic cfg_cpol,
  input  logic sck_in,
  output logic sck_out,
  output logic lead_edge,
  output logic trail_edge
);
  logic wrap;
  logic ph_q, ph_d;
  logic [SYNC_STAGES:0] sync_q;
  logic ext_now, ext_old;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign wrap = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q, cnt_d;
      assign wrap = (cnt_q == CW'(HALF_DIV - 1));
      always_comb cnt_d = wrap ? '0 : cnt_q + 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb ph_d = wrap ? ~ph_q : ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      sync_q <= '0;
    end else begin
      ph_q   <= ph_d;
      sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
    end
  end

  assign ext_now = sync_q[SYNC_STAGES-1] ^ cfg_cpol;
  assign ext_old = sync_q[SYNC_STAGES] ^ cfg_cpol;

  assign sck_out    = ph_q ^ cfg_cpol;
  assign lead_edge  = cfg_clk_master ? (wrap & ~ph_q) : (ext_now & ~ext_old);
  assign trail_edge = cfg_clk_master ? (wrap &  ph_q) : (~ext_now & ext_old);
endmodule

// File: rtl/fspi_ctrl.sv
// Frame sequencing, transmit buffer and shift register.
module fspi_ctrl
  import fspi_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_edge,
  input  logic              trail_edge,
  input  logic              cfg_frame_master,
  input  logic              cfg_wide,
  input  logic              fs_in,
  input  logic              sdi,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              fs_out,
  output logic              sdo,
  output logic              tx_full,
  output logic              word_fin,
  output logic [DATA_W-1:0] rx_word,
  output logic              done
);
  localparam int CW = $clog2(DATA_W + 1);

  fspi_state_e       state_q, state_d;
  logic [DATA_W-1:0] sr_q, sr_d, txbuf_q, txbuf_d, shifted;
  logic [CW-1:0]     bit_q, bit_d;
  logic              full_q, full_d, fs_q, fs_d, sdo_q, sdo_d, done_q, done_d;
  logic              load, last, sr_msb, buf_msb;

  assign sr_msb  = cfg_wide ? sr_q[DATA_W-1]    : sr_q[NARROW_W-1];
  assign buf_msb = cfg_wide ? txbuf_q[DATA_W-1] : txbuf_q[NARROW_W-1];
  assign last    = (bit_q == (cfg_wide ? CW'(DATA_W - 1) : CW'(NARROW_W - 1)));
  assign shifted = {sr_q[DATA_W-2:0], sdi};

  always_comb begin
    state_d  = state_q;
    sr_d     = sr_q;
    bit_d    = bit_q;
    fs_d     = fs_q;
    sdo_d    = sdo_q;
    done_d   = 1'b0;
    load     = 1'b0;
    word_fin = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_frame_master) begin
          if (lead_edge && full_q) begin
            fs_d    = 1'b1;
            state_d = ST_SYNC;
          end
        end else if (trail_edge && fs_in) begin
          sr_d    = txbuf_q;
          load    = 1'b1;
          state_d = ST_LEAD;
        end
      end
      ST_SYNC: begin
        if (lead_edge) begin
          fs_d    = 1'b0;
          sr_d    = txbuf_q;
          sdo_d   = buf_msb;
          load    = 1'b1;
          bit_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_LEAD: begin
        if (lead_edge) begin
          sdo_d   = sr_msb;
          bit_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (lead_edge) sdo_d = sr_msb;
        if (trail_edge) begin
          sr_d  = shifted;
          bit_d = bit_q + 1'b1;
          if (last) begin
            word_fin = 1'b1;
            done_d   = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    txbuf_d = tx_wr ? tx_data : txbuf_q;
    full_d  = tx_wr ? 1'b1 : (load ? 1'b0 : full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      txbuf_q <= '0;
      bit_q   <= '0;
      full_q  <= 1'b0;
      fs_q    <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      txbuf_q <= txbuf_d;
      bit_q   <= bit_d;
      full_q  <= full_d;
      fs_q    <= fs_d;
      sdo_q   <= sdo_d;
      done_q  <= done_d;
    end
  end

  assign rx_word = cfg_wide ? shifted : {{(DATA_W-NARROW_W){1'b0}}, shifted[NARROW_W-1:0]};
  assign fs_out  = fs_q;
  assign sdo     = sdo_q;
  assign tx_full = full_q;
  assign done    = done_q;
endmodule

// File: rtl/fspi_rxbuf.sv
// One-entry receive buffer with sticky overflow.
module fspi_rxbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_fin,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_rd,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovf
);
  logic [DATA_W-1:0] data_q, data_d;
  logic full_q, full_d, ovf_q, ovf_d, store, spill;

  always_comb begin
    store  = word_fin && !full_q && !ovf_q;
    spill  = word_fin && (full_q || ovf_q);
    data_d = store ? rx_word : data_q;
    full_d = store ? 1'b1 : (rx_rd ? 1'b0 : full_q);
    ovf_d  = spill ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign rx_ovf  = ovf_q;
endmodule

// File: rtl/fspi_frame_engine.sv
module fspi_frame_engine #(
  parameter int DATA_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_master,
  input  logic              cfg_frame_master,
  input  logic              cfg_cpol,
  input  logic              cfg_wide,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  input  logic              sdi,
  output logic              sdo,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovf,
  input  logic              ovf_clr,
  output logic              done
);
  logic              lead_edge, trail_edge, word_fin;
  logic [DATA_W-1:0] rx_word;

  fspi_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .cfg_clk_master(cfg_clk_master), .cfg_cpol(cfg_cpol),
    .sck_in(sck_in), .sck_out(sck_out), .lead_edge(lead_edge), .trail_edge(trail_edge)
  );

  fspi_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lead_edge(lead_edge), .trail_edge(trail_edge),
    .cfg_frame_master(cfg_frame_master), .cfg_wide(cfg_wide), .fs_in(fs_in), .sdi(sdi),
    .tx_wr(tx_wr), .tx_data(tx_data), .fs_out(fs_out), .sdo(sdo), .tx_full(tx_full),
    .word_fin(word_fin), .rx_word(rx_word), .done(done)
  );

  fspi_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .word_fin(word_fin), .rx_word(rx_word), .rx_rd(rx_rd),
    .ovf_clr(ovf_clr), .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf)
  );

  assign sck_oe = cfg_clk_master;
  assign fs_oe  = cfg_frame_master;
endmodule

// File: rtl/fspi_frame_chk.sv
module fspi_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic lead_edge,
  input logic cfg_frame_master,
  input logic tx_wr,
  input logic tx_full,
  input logic fs_out,
  input logic sdo,
  input logic done,
  input logic rx_full,
  input logic rx_rd,
  input logic rx_ovf
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_TXFULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) tx_wr |=> tx_full); // R11
  AST_FS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fs_out && !lead_edge) |=> fs_out); // R3
  AST_FS_DROP: assert property (@(posedge clk) disable iff (!rst_n) (fs_out && lead_edge) |=> !fs_out); // R3
  AST_FS_QUIET_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_frame_master |-> !fs_out); // R3
  AST_SDO_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n) !lead_edge |=> $stable(sdo)); // R7
  AST_FS_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n) !lead_edge |=> $stable(fs_out)); // R7
  AST_RXFULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_full && !rx_rd) |=> rx_full); // R9
  AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_ovf) |-> done); // R9
endmodule

bind fspi_frame_engine fspi_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lead_edge(lead_edge), .cfg_frame_master(cfg_frame_master),
  .tx_wr(tx_wr), .tx_full(tx_full), .fs_out(fs_out), .sdo(sdo), .done(done),
  .rx_full(rx_full), .rx_rd(rx_rd), .rx_ovf(rx_ovf)
);

// File: tb/tb_fspi_frame_engine.sv
module tb_fspi_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int EXT_HALF   = 6;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic cm, fm, cpol, wide;
  logic sck_ext, fs_in, sdi, tx_wr, rx_rd, ovf_clr;
  logic [15:0] tx_data;
  logic sck_out, sck_oe, fs_out, fs_oe, sdo, tx_full, rx_full, rx_ovf, done;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, cap_cnt = 0, lead_cnt = 0;
  int fs_len = 0, last_fs_len = 0, r7_seen = 0, r7_bad = 0;
  int p_st = 0, p_bits = 0;
  logic [15:0] p_sr, cap, peer_word;
  logic ph_prev = 1'b0, sck_prev = 1'b0, fs_prev = 1'b0, sdo_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fspi_frame_engine #(.DATA_W(16), .NARROW_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_master(cm), .cfg_frame_master(fm), .cfg_cpol(cpol),
    .cfg_wide(wide), .sck_in(sck_ext), .sck_out(sck_out), .sck_oe(sck_oe), .fs_in(fs_in),
    .fs_out(fs_out), .fs_oe(fs_oe), .sdi(sdi), .sdo(sdo), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf),
    .ovf_clr(ovf_clr), .done(done)
  );

  always begin
    repeat (EXT_HALF) @(negedge clk);
    sck_ext <= ~sck_ext;
  end

  // Serial peer and monitors, all evaluated away from the active edge.
  always @(negedge clk) begin
    logic pin, ph, fspin;
    int nb;
    pin   = cm ? sck_out : sck_ext;
    ph    = pin ^ cpol;
    fspin = fm ? fs_out : fs_in;
    nb    = wide ? 16 : 8;
    if (rst_n) begin
      if (done) done_cnt++;
      if (fs_out) fs_len++;
      else if (fs_prev) begin last_fs_len = fs_len; fs_len = 0; end
      if (cm) begin
        if (fs_out && !fs_prev) begin
          r7_seen++;
          if (!(sck_out != cpol && sck_prev == cpol)) r7_bad++;
        end
        if (sdo != sdo_prev) begin
          r7_seen++;
          if (!(sck_out != cpol && sck_prev == cpol)) r7_bad++;
        end
      end
      if (ph && !ph_prev) begin
        lead_cnt++;
        if (p_st != 0) begin
          sdi  = p_sr[nb-1];
          p_sr = p_sr << 1;
          p_st = 2;
        end
      end
      if (!ph && ph_prev) begin
        if (p_st == 2) begin
          cap = {cap[14:0], sdo};
          p_bits++;
          if (p_bits == nb) begin p_st = 0; cap_cnt++; end
        end else if (p_st == 0 && fspin) begin
          p_st = 1; p_sr = peer_word; p_bits = 0; cap = '0;
        end
      end
    end
    ph_prev  = ph;
    sck_prev = sck_out;
    fs_prev  = fs_out;
    sdo_prev = sdo;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_w(input logic [15:0] w, input logic wd);
    return wd ? w : {8'h00, w[7:0]};
  endfunction

  task automatic set_mode(input logic c, input logic f, input logic p, input logic w);
    cm = c; fm = f; cpol = p; wide = w;
    repeat (40) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] w);
    tx_data = w; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic send_fs();
    int l0;
    l0 = lead_cnt;
    wait (lead_cnt != l0);
    fs_in = 1'b1;
    l0 = lead_cnt;
    wait (lead_cnt != l0);
    fs_in = 1'b0;
  endtask

  task automatic wait_word(input int d0, input int c0);
    wait (done_cnt != d0 && cap_cnt != c0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] w, input logic [15:0] pw, input bit wr, output int d0);
    int c0;
    d0 = done_cnt; c0 = cap_cnt; peer_word = pw;
    if (wr) write_word(w);
    if (!fm) send_fs();
    wait_word(d0, c0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0, tog;
    logic [15:0] a, b, pa, pb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cm = 1'b1; fm = 1'b1; cpol = 1'b0; wide = 1'b1;
    sck_ext = 1'b0; fs_in = 1'b0; sdi = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; ovf_clr = 1'b0;
    tx_data = '0; peer_word = '0; p_sr = '0; cap = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({tx_full, rx_full, rx_ovf, fs_out, done} == 5'b0, "R1 reset state",
          {tx_full, rx_full, rx_ovf, fs_out, done}, 0);

    // R2: free-running internal clock with no traffic
    tog = 0;
    for (int i = 0; i < 120; i++) begin
      logic s0;
      s0 = sck_out;
      @(negedge clk);
      if (sck_out != s0) tog++;
    end
    check(tog == 120 / HALF, "R2 internal sck toggles", tog, 120 / HALF);
    check(sck_oe == 1'b1 && fs_oe == 1'b1, "R2 R3 drive enables as master", {sck_oe, fs_oe}, 2'b11);

    // Frame master, internal clock, 16-bit
    a = 16'hA5C3; pa = 16'h3C5A;
    d0 = done_cnt; peer_word = pa;
    write_word(a);
    check(tx_full == 1'b1, "R11 tx_full after write", tx_full, 1);
    wait_word(d0, cap_cnt - 0 == cap_cnt ? cap_cnt : cap_cnt);
    check(cap == a, "R4 sdo word frame master 16b", cap, a);
    check(rx_data == pa && rx_full, "R5 rx word frame master 16b", rx_data, pa);
    check(last_fs_len == 2 * HALF, "R3 sync width one period", last_fs_len, 2 * HALF);
    check(tx_full == 1'b0, "R11 tx_full cleared by load", tx_full, 0);
    check(done_cnt == d0 + 1, "R10 one done per word", done_cnt - d0, 1);
    pulse_rd();

    // R7: polarity 1, 8-bit, internal clock
    set_mode(1'b1, 1'b1, 1'b1, 1'b0);
    xfer(16'h1E96, 16'hBEEF, 1'b1, d0);
    check(cap == 16'h0096, "R7 R4 cpol1 8b sdo", cap, 16'h0096);
    check(rx_data == 16'h00EF, "R7 R5 cpol1 8b rx upper zero", rx_data, 16'h00EF);
    pulse_rd();

    // External clock, frame slave
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    check(sck_oe == 1'b0 && fs_oe == 1'b0 && fs_out == 1'b0, "R2 R3 enables off as slave",
          {sck_oe, fs_oe, fs_out}, 0);
    xfer(16'h8001, 16'h7FFE, 1'b1, d0);
    check(cap == 16'h8001, "R4 sdo word frame slave ext", cap, 16'h8001);
    check(rx_data == 16'h7FFE, "R5 rx word frame slave ext", rx_data, 16'h7FFE);
    pulse_rd();
    xfer(16'h0000, 16'h1234, 1'b0, d0);
    check(cap == 16'h8001, "R6 resend without write", cap, 16'h8001);
    pulse_rd();

    // R8: sync during a word is ignored, pending word stays buffered
    a = 16'hC0DE; b = 16'h5AA5; pa = 16'h0F0F;
    d0 = done_cnt; peer_word = pa;
    begin
      int c0, l0;
      c0 = cap_cnt;
      write_word(a);
      send_fs();
      write_word(b);
      l0 = lead_cnt;
      wait (lead_cnt >= l0 + 3);
      send_fs();
      wait_word(d0, c0);
    end
    check(cap == a, "R8 word unaffected by mid-word sync", cap, a);
    check(tx_full == 1'b1, "R8 pending word still buffered", tx_full, 1);
    repeat (60) @(negedge clk);
    check(done_cnt == d0 + 1, "R8 no extra word started", done_cnt - d0, 1);
    pulse_rd();
    xfer(16'h0000, 16'h2222, 1'b0, d0);
    check(cap == b, "R8 pending word sent on next sync", cap, b);
    pulse_rd();

    // R9: overflow
    xfer(16'h1111, 16'hAAAA, 1'b1, d0);
    xfer(16'h2222, 16'hBBBB, 1'b1, d0);
    check(rx_ovf == 1'b1 && rx_data == 16'hAAAA, "R9 overflow keeps old word", rx_data, 16'hAAAA);
    check(done_cnt == d0 + 1, "R10 done on dropped word", done_cnt - d0, 1);
    pulse_rd();
    xfer(16'h3333, 16'hCCCC, 1'b1, d0);
    check(rx_full == 1'b0 && rx_data == 16'hAAAA, "R9 dropped while overflow set", rx_full, 0);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check(rx_ovf == 1'b0, "R9 overflow cleared", rx_ovf, 0);
    xfer(16'h4444, 16'hDDDD, 1'b1, d0);
    check(rx_full && rx_data == 16'hDDDD, "R9 store after clear", rx_data, 16'hDDDD);
    pulse_rd();

    // Random words across all pairings
    for (int i = 0; i < 24; i++) begin
      logic [3:0] m;
      logic [15:0] w, pw;
      m  = 4'($urandom);
      w  = 16'($urandom);
      pw = 16'($urandom);
      set_mode(m[0], m[1], m[2], m[3]);
      xfer(w, pw, 1'b1, d0);
      check(cap == mask_w(w, m[3]), "R4 random sdo", cap, mask_w(w, m[3]));
      check(rx_data == mask_w(pw, m[3]), "R5 random rx", rx_data, mask_w(pw, m[3]));
      check(done_cnt == d0 + 1, "R10 random single done", done_cnt - d0, 1);
      pulse_rd();
    end

    check(r7_seen > 0 && r7_bad == 0, "R7 outputs change on leading edge", r7_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule